// File: doc/BRIEF.md
# Two-Cycle Decimal Adjust Unit

This unit produces packed-BCD sums and differences of two multi-digit operands by running a binary nibble adder in the first cycle and a correction add in the second. In the first cycle every 4-bit digit is added on its own, with no carry passing from one digit to the next. For each digit the unit records whether the binary value needs correcting. The correction value for the lowest digit is complete at the end of this cycle. For every higher digit only a few threshold bits are stored.

In the second cycle the stored binary digits are the A side of the add and the correction values are the B side. A higher digit's correction value takes the decimal carry from the digit below it in bit 0. The detect thresholds for that digit are moved to match. The same cycle produces the carry out and the N, Z and V flags.

A per-operation mode input picks one of two flag conventions. In the first, the flags come from the corrected result. In the second, they come from the uncorrected binary sum, with the decimal low carry added into each upper digit by a 4-bit incrementer. Operations are pipelined, so a new one may start on every cycle.

Top module: `bcd2c_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `valid` is 0 and `result`, `cout` and the flags are 0.
- R2: An operation sampled with `start`=1 on a rising edge gives `valid`=1 for exactly one cycle after the second rising edge that follows. `start` may be 1 on every cycle, with one result per cycle. When `start` is low, no `valid` appears two edges later.
- R3: With `sub`=0 and BCD operands (each digit 0..9), `result` is the BCD value of (a+b+cin) mod 100. `cout` is 1 when that sum exceeds 99.
- R4: With `sub`=1 and BCD operands, `result` is the BCD value of (a-b-(1-cin)) mod 100. `cout` is 1 when no borrow occurred, that is when the difference is not negative.
- R5: `cin` counts as an incoming carry for add and as the inverse of an incoming borrow for subtract. For example, 00-00 with `cin`=0 gives 99 with `cout`=0, and 00+00 with `cin`=1 gives 01.
- R6: A correction in the low digit carries into the next digit. For example, 09+01 gives 10 with `cout`=0, and 99+01 gives 00 with `cout`=1.
- R7: With `flag_mode`=0, `flag_n` is bit 7 of `result` and `flag_z` is 1 when `result` is zero. `flag_v` is 1 when the MSB of a equals the MSB of the effective B (b for add, ~b for subtract) and the MSB of `result` differs from that MSB.
- R8: With `flag_mode`=1, the N, Z and V rules of R7 are applied to a value M instead of `result`. The low digit of M is a_lo+be_lo+cin mod 16. The high digit of M is a_hi+be_hi+k mod 16, where be is the effective B and k is the decimal low carry. For add, k is 1 when the low binary sum exceeds 9. For subtract, k is 1 when the low binary sum reaches 16. For example, 99+01 gives M=AA, so N=1 and Z=0.
- R9: `flag_mode`, `sub` and `cin` are sampled together with the operands on the `start` edge. Consecutive operations may use different settings.
- R10: In cycles where `valid` is 0, `result`, `cout` and the flags keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts an operation on the operands present at this edge |
| sub | input | 1 | 0 = add, 1 = subtract |
| flag_mode | input | 1 | 0 = flags from corrected result, 1 = flags from binary sum plus low carry |
| cin | input | 1 | Carry in (inverse of borrow when subtracting) |
| a | input | 4*DIGITS | Operand A, packed BCD |
| b | input | 4*DIGITS | Operand B, packed BCD |
| valid | output | 1 | Result strobe, one cycle per operation |
| result | output | 4*DIGITS | Packed BCD result |
| cout | output | 1 | Decimal carry out (not-borrow for subtract) |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The correction cycle of one operation overlaps the binary-add cycle of the next, because both use the stage registers on the same edge. The bench provokes this by issuing starts back to back, with random gaps and with random flag mode, operation and carry-in on each start. It sweeps every BCD operand pair in this way. Each result that comes out is compared with a reference computed from that operation's own inputs. A result that picks up a neighbour's mode, sub bit or digits is therefore reported under the requirement it breaks, and idle cycles are checked for hold.

// File: rtl/bcd2c_pkg.sv
// Package: shared types for the two-cycle decimal adjust unit.
// Assumes digits are 4 bits wide.
package bcd2c_pkg;
    localparam int NIB = 4;

    // Per-operation control carried from the first cycle to the second
    typedef struct packed {
        logic vld;
        logic sub;
        logic mode;
        logic a_msb;
        logic be_msb;
    } s1_ctl_t;
endpackage

// File: rtl/bcd2c_split_add.sv
// Cycle-one logic: split-carry binary add, digit by digit, plus detect bits.
// The carry into every digit above the lowest is forced to zero. The low
// digit's correction value is finished here. Upper digits only export
// threshold bits. Assumes DIGITS >= 2.
module bcd2c_split_add #(
    parameter int DIGITS = 2,
    localparam int W = 4 * DIGITS
) (
    input  logic             sub,
    input  logic             cin,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [W-1:0]     sum,
    output logic [3:0]       lo_adj,
    output logic [DIGITS-2:0] up_hc,
    output logic [DIGITS-2:0] up_gt9,
    output logic [DIGITS-2:0] up_eq9,
    output logic [DIGITS-2:0] up_eqf
);
    logic [W-1:0] be;
    logic         lo_need;
    logic [4:0]   lo_raw;

    // Effective B operand: inverted for subtract
    assign be = sub ? ~b : b;

    // Lowest digit takes the real carry in
    assign lo_raw        = {1'b0, a[3:0]} + {1'b0, be[3:0]} + {4'd0, cin};
    assign sum[3:0]      = lo_raw[3:0];

    // Low correction: add needs >9 or carry, subtract needs a borrow
    assign lo_need = sub ? ~lo_raw[4] : (lo_raw[4] | (lo_raw[3:0] > 4'd9));
    assign lo_adj  = {lo_need & sub, lo_need & ~sub, lo_need, 1'b0};

    // Upper digits: independent 4-bit adds with carry in tied low
    for (genvar k = 1; k < DIGITS; k++) begin : g_up
        logic [4:0] raw;
        assign raw             = {1'b0, a[4*k +: 4]} + {1'b0, be[4*k +: 4]};
        assign sum[4*k +: 4]   = raw[3:0];
        assign up_hc[k-1]      = raw[4];
        assign up_gt9[k-1]     = raw[3:0] > 4'd9;
        assign up_eq9[k-1]     = raw[3:0] == 4'd9;
        assign up_eqf[k-1]     = raw[3:0] == 4'hF;
    end
endmodule

// File: rtl/bcd2c_adjust.sv
// Cycle-two logic: forms upper-digit correction values from stored detect
// bits, with the lower digit's decimal carry placed in bit 0. It adds the
// corrections to the stored binary digits. It also builds the binary-plus-
// low-carry value used by the second flag convention.
module bcd2c_adjust #(
    parameter int DIGITS = 2,
    localparam int W = 4 * DIGITS
) (
    input  logic             sub,
    input  logic [W-1:0]     sum,
    input  logic [3:0]       lo_adj,
    input  logic [DIGITS-2:0] up_hc,
    input  logic [DIGITS-2:0] up_gt9,
    input  logic [DIGITS-2:0] up_eq9,
    input  logic [DIGITS-2:0] up_eqf,
    output logic [W-1:0]     res,
    output logic [W-1:0]     mid,
    output logic             cout
);
    // Correction chain across the digits; threshold shifts when a carry is folded in
    always_comb begin
        logic need;
        logic inj;
        logic [3:0] adjv;
        need         = lo_adj[1];
        res[3:0]     = sum[3:0] + lo_adj;
        mid[3:0]     = sum[3:0];
        for (int k = 1; k < DIGITS; k++) begin
            inj  = sub ? ~need : need;
            if (sub)
                need = ~(up_hc[k-1] | (up_eqf[k-1] & inj));
            else
                need = up_hc[k-1] | up_gt9[k-1] | (up_eq9[k-1] & inj);
            adjv = {need & sub, need & ~sub, need, inj};
            res[4*k +: 4] = sum[4*k +: 4] + adjv;
            mid[4*k +: 4] = sum[4*k +: 4] + {3'd0, inj};
        end
        cout = sub ? ~need : need;
    end
endmodule

// File: rtl/bcd2c_flags.sv
// Flag former: picks the corrected result or the binary-plus-carry value
// according to the mode bit, then derives N, Z and V.
module bcd2c_flags #(
    parameter int DIGITS = 2,
    localparam int W = 4 * DIGITS
) (
    input  logic         mode,
    input  logic [W-1:0] res,
    input  logic [W-1:0] mid,
    input  logic         a_msb,
    input  logic         be_msb,
    output logic         n,
    output logic         z,
    output logic         v
);
    logic [W-1:0] src;

    // Source selection by flag convention
    assign src = mode ? mid : res;
    assign n   = src[W-1];
    assign z   = (src == '0);
    assign v   = (a_msb == be_msb) && (src[W-1] != a_msb);
endmodule

// File: rtl/bcd2c_top.sv
// Two-cycle decimal adjust unit. Cycle one registers the split binary sum and
// the detect bits. Cycle two registers the corrected result, carry and flags.
// Fully pipelined: one operation may start each cycle. Result outputs hold
// between valid strobes. Synchronous active-low reset.
module bcd2c_top #(
    parameter int DIGITS = 2,
    localparam int W = 4 * DIGITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         sub,
    input  logic         flag_mode,
    input  logic         cin,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         valid,
    output logic [W-1:0] result,
    output logic         cout,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_v
);
    import bcd2c_pkg::*;

    logic [W-1:0]      c1_sum;
    logic [3:0]        c1_lo_adj;
    logic [DIGITS-2:0] c1_hc, c1_gt9, c1_eq9, c1_eqf;

    s1_ctl_t           s1_ctl;
    logic [W-1:0]      s1_sum;
    logic [3:0]        s1_lo_adj;
    logic [DIGITS-2:0] s1_hc, s1_gt9, s1_eq9, s1_eqf;

    logic [W-1:0]      c2_res, c2_mid;
    logic              c2_cout, c2_n, c2_z, c2_v;

    bcd2c_split_add #(.DIGITS(DIGITS)) u_add (
        .sub(sub), .cin(cin), .a(a), .b(b),
        .sum(c1_sum), .lo_adj(c1_lo_adj),
        .up_hc(c1_hc), .up_gt9(c1_gt9), .up_eq9(c1_eq9), .up_eqf(c1_eqf)
    );

    // Stage one: capture binary digits, detect bits and control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_ctl    <= '0;
            s1_sum    <= '0;
            s1_lo_adj <= '0;
            s1_hc     <= '0;
            s1_gt9    <= '0;
            s1_eq9    <= '0;
            s1_eqf    <= '0;
        end else begin
            s1_ctl.vld <= start;
            if (start) begin
                s1_ctl.sub    <= sub;
                s1_ctl.mode   <= flag_mode;
                s1_ctl.a_msb  <= a[W-1];
                s1_ctl.be_msb <= b[W-1] ^ sub;
                s1_sum        <= c1_sum;
                s1_lo_adj     <= c1_lo_adj;
                s1_hc         <= c1_hc;
                s1_gt9        <= c1_gt9;
                s1_eq9        <= c1_eq9;
                s1_eqf        <= c1_eqf;
            end
        end
    end

    bcd2c_adjust #(.DIGITS(DIGITS)) u_adj (
        .sub(s1_ctl.sub), .sum(s1_sum), .lo_adj(s1_lo_adj),
        .up_hc(s1_hc), .up_gt9(s1_gt9), .up_eq9(s1_eq9), .up_eqf(s1_eqf),
        .res(c2_res), .mid(c2_mid), .cout(c2_cout)
    );

    bcd2c_flags #(.DIGITS(DIGITS)) u_flg (
        .mode(s1_ctl.mode), .res(c2_res), .mid(c2_mid),
        .a_msb(s1_ctl.a_msb), .be_msb(s1_ctl.be_msb),
        .n(c2_n), .z(c2_z), .v(c2_v)
    );

    // Stage two: publish the corrected result and flags, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            result <= '0;
            cout   <= 1'b0;
            flag_n <= 1'b0;
            flag_z <= 1'b0;
            flag_v <= 1'b0;
        end else begin
            valid <= s1_ctl.vld;
            if (s1_ctl.vld) begin
                result <= c2_res;
                cout   <= c2_cout;
                flag_n <= c2_n;
                flag_z <= c2_z;
                flag_v <= c2_v;
            end
        end
    end
endmodule

// File: rtl/bcd2c_chk.sv
// Checker for the decimal adjust unit, bound to the top. It tracks its own
// two-deep copy of the start, mode and operand-is-BCD attributes.
module bcd2c_chk #(
    parameter int DIGITS = 2,
    localparam int W = 4 * DIGITS
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         flag_mode,
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic         valid,
    input logic [W-1:0] result,
    input logic         cout,
    input logic         flag_n,
    input logic         flag_z
);
    function automatic logic all_digits_ok(input logic [W-1:0] x);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < DIGITS; k++)
            if (x[4*k +: 4] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    logic p1_bcd, p2_bcd, p1_mode, p2_mode;

    // Shadow pipeline of per-operation attributes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p1_bcd <= 1'b0; p2_bcd <= 1'b0;
            p1_mode <= 1'b0; p2_mode <= 1'b0;
        end else begin
            p1_bcd  <= start && all_digits_ok(a) && all_digits_ok(b);
            p2_bcd  <= p1_bcd;
            p1_mode <= flag_mode;
            p2_mode <= p1_mode;
        end
    end

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ##2 valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !start |-> ##2 !valid);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> ($stable(result) && $stable(cout)));
    a_r3_digits_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && p2_bcd) |-> all_digits_ok(result));
    a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !p2_mode) |-> (flag_z == (result == '0)));
    a_r7_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !p2_mode) |-> (flag_n == result[W-1]));
endmodule

bind bcd2c_top bcd2c_chk #(.DIGITS(DIGITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .flag_mode(flag_mode),
    .a(a), .b(b), .valid(valid), .result(result), .cout(cout),
    .flag_n(flag_n), .flag_z(flag_z)
);

// File: tb/tb_bcd2c_top.sv
// Bench: full BCD sweep with random gaps and random mode, sub and carry-in,
// plus directed corners. The expected values come from decimal arithmetic.
module tb_bcd2c_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n, start, sub, flag_mode, cin;
    logic [7:0] a, b;
    logic valid, cout, flag_n, flag_z, flag_v;
    logic [7:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Expected pipeline: slot 1 issued last negedge, slot 2 the one before
    logic       p1_v = 0, p2_v = 0;
    logic [7:0] p1_r = 0, p2_r = 0;
    logic [3:0] p1_f = 0, p2_f = 0;
    logic       p1_s = 0, p2_s = 0;
    logic [7:0] last_r = 0;
    logic [3:0] last_f = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd2c_top dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sub(sub),
        .flag_mode(flag_mode), .cin(cin), .a(a), .b(b),
        .valid(valid), .result(result), .cout(cout),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] to_bcd(input int x);
        return 8'((x / 10) * 16 + (x % 10));
    endfunction

    // Reference model from R3..R8; flags packed as {cout,n,z,v}
    function automatic void ref_op(input int av, input int bv, input bit sb,
                                   input bit ci, input bit md,
                                   output logic [7:0] r, output logic [3:0] f);
        logic [7:0] ab, bb, be, m, src;
        int t, lo, inj, hi;
        logic c;
        ab = to_bcd(av);
        bb = to_bcd(bv);
        if (!sb) begin
            t = av + bv + int'(ci);
            c = (t > 99);
            t = t % 100;
        end else begin
            t = av - bv - (1 - int'(ci));
            c = (t >= 0);
            if (t < 0) t = t + 100;
        end
        r   = to_bcd(t);
        be  = sb ? ~bb : bb;
        lo  = int'(ab[3:0]) + int'(be[3:0]) + int'(ci);
        inj = sb ? int'(lo > 15) : int'(lo > 9);
        hi  = (int'(ab[7:4]) + int'(be[7:4]) + inj) % 16;
        m   = 8'(hi * 16 + (lo % 16));
        src = md ? m : r;
        f   = {c, src[7], src == 8'h00, (ab[7] == be[7]) && (src[7] != ab[7])};
    endfunction

    // One cycle: check what was issued two negedges ago, then drive a new op
    task automatic step(input bit st, input int av, input int bv,
                        input bit sb, input bit ci, input bit md);
        logic [7:0] r;
        logic [3:0] f;
        @(negedge clk);
        chk("R2 valid timing", {7'd0, valid}, {7'd0, p2_v});
        if (p2_v) begin
            chk(p2_s ? "R4 sub result" : "R3 add result", result, p2_r);
            chk(p2_s ? "R4 sub cout" : "R3 add cout", {7'd0, cout}, {7'd0, p2_f[3]});
            chk("R7/R8 R9 flags", {5'd0, flag_n, flag_z, flag_v}, {5'd0, p2_f[2:0]});
            last_r = p2_r;
            last_f = p2_f;
        end else begin
            chk("R10 hold result", result, last_r);
            chk("R10 hold flags", {4'd0, cout, flag_n, flag_z, flag_v}, {4'd0, last_f});
        end
        p2_v = p1_v; p2_r = p1_r; p2_f = p1_f; p2_s = p1_s;
        ref_op(av, bv, sb, ci, md, r, f);
        p1_v = st; p1_r = r; p1_f = f; p1_s = sb;
        start = st; a = to_bcd(av); b = to_bcd(bv);
        sub = sb; cin = ci; flag_mode = md;
    endtask

    // Watchdog: an overrun is a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; start = 0; sub = 0; cin = 0; flag_mode = 0; a = 0; b = 0;
        repeat (3) @(negedge clk);
        // R1: reset state during reset
        chk("R1 reset valid", {7'd0, valid}, 8'd0);
        chk("R1 reset result", result, 8'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 post-reset outputs", {3'd0, valid, cout, flag_n, flag_z, flag_v}, 8'd0);

        // Directed corners (R5, R6, R8, R9 with mode switching back to back)
        step(1,  9,  1, 0, 0, 0);   // R6: 09+01 -> 10
        step(1, 99,  1, 0, 0, 0);   // R6: 99+01 -> 00 cout
        step(1, 99,  1, 0, 0, 1);   // R8: M = AA
        step(1,  0,  0, 1, 0, 0);   // R5: 00-00-borrow -> 99, cout 0
        step(1,  0,  0, 0, 1, 1);   // R5: 00+00+1 -> 01
        step(1, 10,  1, 1, 1, 0);   // R4: 10-01 -> 09
        step(1,  0,  0, 0, 0, 0);   // R7: zero flag
        step(0,  0,  0, 0, 0, 0);   // R10 idle
        step(0, 55, 55, 1, 1, 1);   // R10 inputs without start
        step(0,  0,  0, 0, 0, 0);
        step(1, 50, 50, 1, 1, 1);   // R8 subtract
        step(1, 80, 30, 0, 0, 0);   // R7 overflow path

        // Full sweep with random gaps and attributes (R2, R3, R4, R9)
        for (int ai = 0; ai < 100; ai++) begin
            for (int bi = 0; bi < 100; bi++) begin
                for (int op = 0; op < 4; op++) begin
                    if (($urandom % 8) == 0)
                        step(0, int'($urandom % 100), int'($urandom % 100), 0, 0, 0);
                    step(1, ai, bi, op[1], op[0], bit'($urandom % 2));
                end
            end
        end
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule